// File: doc/BRIEF.md
# Modem Status Loopback Tracker

This block produces the 8-bit modem status value of a PC-style serial port while the port runs in internal loopback. In that mode the four modem control outputs are turned back into the four modem status inputs. Each update cycle with loopback enabled does two things. First, the block compares the incoming control bits with the line-state bits it currently holds and sets sticky change flags. Then it reloads the line-state bits from the control bits.

A read of the status register is signalled by a one-cycle clear pulse, which wipes all eight bits. When that clear pulse coincides with a change detected in the same cycle, the fresh change survives. While loopback is off and no clear arrives, the value holds and the control bits are ignored.

Top module: `mdm_loop_status`

## Requirements
- R1: While reset is asserted, and in the first cycle after it is released, the status value is 0x00.
- R2: In a cycle with loopback enabled, the line-state bits take their values from the control bits. Control bits are DTR=bit0, RTS=bit1, OUT1=bit2 and OUT2=bit3. The mapping is status bit4 (clear-to-send) from RTS, bit5 (data-set-ready) from DTR, bit6 (ring) from OUT1 and bit7 (carrier detect) from OUT2. The new values are visible one clock later.
- R3: In a loopback cycle, status bit0 is set when RTS differs from the held bit4, and status bit1 is set when DTR differs from the held bit5.
- R4: In a loopback cycle, status bit3 is set when OUT2 differs from the held bit7, whichever direction the change goes.
- R5: In a loopback cycle, status bit2 is set only when the held bit6 is 1 and OUT1 is 0. A rising ring line never sets it.
- R6: Change flags (bits 0 to 3) stay set until a clear pulse, even while loopback continues with unchanged control bits.
- R7: A clear pulse in a cycle without loopback sets all eight status bits to 0.
- R8: A clear pulse in a loopback cycle drops every earlier change flag. It keeps only the changes detected in that same cycle, and it reloads the line-state bits from the control bits.
- R9: With loopback off and no clear pulse, the status value holds whatever the control bits do.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ctrl_i | input | 4 | Modem control bits: DTR, RTS, OUT1, OUT2 from bit 0 up |
| loop_en_i | input | 1 | Loopback enable; each high cycle is one update |
| rd_clr_i | input | 1 | One-cycle status read, clears the value |
| status_o | output | 8 | Change flags in bits 3:0, line states in bits 7:4 |

## Verification
The bench sweeps every pair of held and new control values under each combination of loopback and clear pulse. This exposes a ring detector that also fires on a rising line, a swapped RTS/DTR mapping, and a clear that wins over a freshly detected change. Directed steps then confirm two more corner cases. The first is that flags persist through quiet loopback cycles, which a design that recomputed rather than accumulated the flags would lose. The second is that control changes with loopback off leave the value frozen, which a design reloading the lines unconditionally would break.

// File: rtl/mdm_loop_pkg.sv
`timescale 1ns/1ps
package mdm_loop_pkg;
   typedef enum logic {DET_ANY = 1'b0, DET_FALL = 1'b1} det_mode_e;

   localparam int unsigned LINE_N = 4;

   // line order inside each nibble of the status value
   localparam int unsigned LN_CTS = 0;
   localparam int unsigned LN_DSR = 1;
   localparam int unsigned LN_RI  = 2;
   localparam int unsigned LN_DCD = 3;

   // control bit positions
   localparam int unsigned CB_DTR  = 0;
   localparam int unsigned CB_RTS  = 1;
   localparam int unsigned CB_OUT1 = 2;
   localparam int unsigned CB_OUT2 = 3;

   function automatic int unsigned line_src(input int unsigned ln);
      case (ln)
         LN_CTS:  return CB_RTS;
         LN_DSR:  return CB_DTR;
         LN_RI:   return CB_OUT1;
         default: return CB_OUT2;
      endcase
   endfunction

   function automatic det_mode_e line_mode(input int unsigned ln);
      return (ln == LN_RI) ? DET_FALL : DET_ANY;
   endfunction
endpackage

// File: rtl/mdm_loop_cell.sv
`timescale 1ns/1ps
module mdm_loop_cell
   import mdm_loop_pkg::*;
#(
   parameter det_mode_e MODE = DET_ANY
) (
   input  logic clk,
   input  logic rst_n,
   input  logic upd_i,
   input  logic clr_i,
   input  logic drv_i,
   output logic state_o,
   output logic flag_o
);
   logic state_q, flag_q, hit;

   generate
      if (MODE == DET_FALL) begin : g_fall
         assign hit = upd_i & state_q & ~drv_i;
      end else begin : g_any
         assign hit = upd_i & (state_q ^ drv_i);
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q <= 1'b0;
         flag_q  <= 1'b0;
      end else begin
         flag_q <= clr_i ? hit : (flag_q | hit);
         if (upd_i)      state_q <= drv_i;
         else if (clr_i) state_q <= 1'b0;
      end
   end

   assign state_o = state_q;
   assign flag_o  = flag_q;
endmodule

// File: rtl/mdm_loop_status.sv
`timescale 1ns/1ps
module mdm_loop_status
   import mdm_loop_pkg::*;
#(
   parameter int unsigned LINES  = LINE_N,
   parameter int unsigned CTRL_W = 4
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic [CTRL_W-1:0]    ctrl_i,
   input  logic                 loop_en_i,
   input  logic                 rd_clr_i,
   output logic [2*LINES-1:0]   status_o
);
   localparam int unsigned STAT_W = 2 * LINES;

   generate
      if (LINES != LINE_N) begin : g_bad_lines
         $error("mdm_loop_status: LINES must equal %0d", LINE_N);
      end
      if (CTRL_W != LINE_N) begin : g_bad_ctrl
         $error("mdm_loop_status: CTRL_W must equal %0d", LINE_N);
      end
   endgenerate

   logic [LINES-1:0] line_st, line_fl;

   generate
      for (genvar g = 0; g < LINES; g++) begin : g_line
         localparam int unsigned SRC = line_src(g);
         mdm_loop_cell #(.MODE(line_mode(g))) cell_i (
            .clk     (clk),
            .rst_n   (rst_n),
            .upd_i   (loop_en_i),
            .clr_i   (rd_clr_i),
            .drv_i   (ctrl_i[SRC]),
            .state_o (line_st[g]),
            .flag_o  (line_fl[g])
         );
      end
   endgenerate

   assign status_o[STAT_W-1:LINES] = line_st;
   assign status_o[LINES-1:0]      = line_fl;
endmodule

// File: rtl/mdm_loop_status_chk.sv
`timescale 1ns/1ps
module mdm_loop_status_chk (
   input logic       clk,
   input logic       rst_n,
   input logic [3:0] ctrl_i,
   input logic       loop_en_i,
   input logic       rd_clr_i,
   input logic [7:0] status_o
);
   // R2
   line_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
      loop_en_i |=> status_o[7:4] == {$past(ctrl_i[3]), $past(ctrl_i[2]), $past(ctrl_i[0]), $past(ctrl_i[1])});

   // R4
   dcd_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (loop_en_i && (ctrl_i[3] != status_o[7])) |=> status_o[3]);

   // R5
   ring_rise_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (loop_en_i && !rd_clr_i && !status_o[2] && !status_o[6]) |=> !status_o[2]);

   // R6
   flag_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !rd_clr_i |=> ((status_o[3:0] & $past(status_o[3:0])) == $past(status_o[3:0])));

   // R7
   clear_all_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_clr_i && !loop_en_i) |=> status_o == 8'h00);

   // R9
   idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!rd_clr_i && !loop_en_i) |=> $stable(status_o));
endmodule

bind mdm_loop_status mdm_loop_status_chk chk_i (
   .clk       (clk),
   .rst_n     (rst_n),
   .ctrl_i    (ctrl_i),
   .loop_en_i (loop_en_i),
   .rd_clr_i  (rd_clr_i),
   .status_o  (status_o)
);

// File: tb/mdm_loop_status_tb.sv
`timescale 1ns/1ps
module mdm_loop_status_tb_top;
   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic [3:0] ctrl = 4'h0;
   logic       lp = 1'b0;
   logic       rd = 1'b0;
   logic [7:0] status;
   logic [7:0] exp_v = 8'h00;
   int         errs = 0;
   int         checks = 0;

   always #10 clk = ~clk;

   mdm_loop_status dut_i (
      .clk       (clk),
      .rst_n     (rst_n),
      .ctrl_i    (ctrl),
      .loop_en_i (lp),
      .rd_clr_i  (rd),
      .status_o  (status)
   );

   function automatic logic [7:0] model(input logic [7:0] old, input logic [3:0] c,
                                        input logic l, input logic r);
      logic [3:0] held, hit, d, ln;
      held = old[7:4];
      hit  = l ? {held[3] ^ c[3], held[2] & ~c[2], held[1] ^ c[0], held[0] ^ c[1]} : 4'h0;
      d    = r ? hit : (old[3:0] | hit);
      ln   = l ? {c[3], c[2], c[0], c[1]} : (r ? 4'h0 : held);
      return {ln, d};
   endfunction

   task automatic step(input logic [3:0] c, input logic l, input logic r);
      ctrl = c; lp = l; rd = r;
      @(posedge clk);
      exp_v = model(exp_v, c, l, r);
      @(negedge clk);
   endtask

   task automatic chk(input string tag, input logic [7:0] e);
      checks++;
      if (status !== e) begin
         errs++;
         $display("FAIL %s: status=%h expected=%h", tag, status, e);
      end
   endtask

   initial begin
      #(20 * 200000);
      errs++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("Result: errors=%0d of %0d checks", errs, checks);
      $finish;
   end

   initial begin
      repeat (3) @(negedge clk);
      chk("R1 in reset", 8'h00);
      rst_n = 1'b1;
      @(negedge clk);
      chk("R1 after release", 8'h00);

      // directed: raise all control bits in loopback
      step(4'hF, 1'b1, 1'b0);
      chk("R2 R3 R4 rise", 8'hFB);           // ring flag stays 0 on rise (R5)
      step(4'hF, 1'b1, 1'b0);
      chk("R6 sticky", 8'hFB);
      step(4'hF, 1'b1, 1'b1);
      chk("R8 clear in loop", 8'hF0);
      step(4'hB, 1'b1, 1'b0);
      chk("R5 ring falls", 8'hB4);
      step(4'h0, 1'b0, 1'b0);
      chk("R9 idle hold", 8'hB4);
      step(4'h5, 1'b0, 1'b0);
      chk("R9 idle hold 2", 8'hB4);
      step(4'h5, 1'b0, 1'b1);
      chk("R7 clear", 8'h00);

      // sweep: held value x new value x loop x clear
      for (int p = 0; p < 16; p++) begin
         for (int n = 0; n < 16; n++) begin
            for (int m = 0; m < 4; m++) begin
               step(4'(p), 1'b1, 1'b0);
               step(4'(p), 1'b1, 1'b1);
               chk("R2 R8 setup", model(8'h00, 4'(p), 1'b1, 1'b0) & 8'hF0);
               step(4'(n), m[0], m[1]);
               chk("R2 R3 R4 R5 R7 R8 R9 sweep", exp_v);
            end
         end
      end

      $display("Result: errors=%0d of %0d checks", errs, checks);
      $finish;
   end
endmodule